// File: doc/BRIEF.md
# Ring-Oscillator Two-Step Time-to-Digital Encoder

This block turns the interval between a start event and a stop event into a 6-bit code. The interval is measured against a free-running nine-stage inverter ring. The coarse part is the number of whole ring periods that pass while start is held high. The fine part is the ring's phase at the stop event, read from the nine tap levels. An odd inverting ring runs through 18 distinct tap patterns per period, so one fine step is one inverter delay and one coarse step is 18 fine steps.

The ring and its tap latches sit outside the block. The block receives a one-cycle pulse for each completed ring period, the start level, a stop strobe aligned to the tap sampling, and the nine latched tap bits. It counts periods, decodes the phase, and merges the two into a saturated code with a valid pulse. A tap pattern with a bubble, meaning more than one transition, is mapped to a nearby legal phase and flagged.

Top module: `tdc_ring_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `code_o`, `valid_o` and `bubble_o` are all 0 after that edge.
- R2: The period counter is cleared at any edge where `start_i` is low. At an edge where `start_i` is high and `wrap_i` is 1, it counts up by one. It holds at 15 instead of wrapping.
- R3: Normalised taps are n[k] = `tap_i`[k] XOR (k odd). A legal phase p in 0..8 has n[k]=1 exactly for k<p. A legal phase p in 9..17 has n[k]=1 exactly for k>=p-9. So phase 0 is all zeros and phase 9 is all ones.
- R4: For a stop strobe at edge k, the reported code is count×18 + phase. Count is the counter value before edge k, so a `wrap_i` at edge k itself is not included.
- R5: When count×18 + phase exceeds 63, the code is 63.
- R6: `valid_o` is high for exactly one cycle, after the second edge following the edge that saw `stop_i` high. `valid_o` is never high otherwise.
- R7: A pattern whose normalised taps have more than one transition between neighbouring stages sets `bubble_o` together with `valid_o`. Let c be the number of ones in n. The phase used is c when n[0]=1, 0 when c=0, and 18−c otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start level; counting is enabled while high |
| wrap_i | input | 1 | One-cycle pulse per completed ring period |
| stop_i | input | 1 | Stop-aligned strobe; the taps are valid in this cycle |
| tap_i | input | 9 | Ring tap levels latched at the stop event |
| code_o | output | 6 | Interval code, saturated to 63 |
| valid_o | output | 1 | One-cycle pulse marking a new code |
| bubble_o | output | 1 | The sampled tap pattern had more than one transition |

## Verification
A wrong period count shows up in `code_o` as an error of a whole multiple of 18, in the first valid pulse after the miscounted wrap. A phase decoder fault shows up as an error of less than 18, or as a wrong `bubble_o`, and only for the tap patterns that reach the faulty term. For that reason all 18 legal phases and several bubble patterns are applied. A pipeline fault moves `valid_o` away from the second edge after the stop strobe, and a per-cycle reference model catches it in that same cycle.

// File: rtl/tdc_pkg.sv
// Shared sizing for the ring-oscillator time encoder.
// Assumes an odd inverting ring, so the number of phases is twice the stage count.
package tdc_pkg;
    localparam int NSTG   = 9;             // inverter stages in the ring
    localparam int NPH    = 2 * NSTG;      // distinct tap patterns per period
    localparam int PW     = $clog2(NPH);   // phase width
    localparam int CW     = 4;             // period counter width
    localparam int OW     = 6;             // output code width
endpackage

// File: rtl/tdc_period_cnt.sv
// Coarse period counter. It counts ring-period pulses while start is high,
// clears while start is low, and holds at its maximum value.
// Assumes wrap_i is already synchronous to clk.
module tdc_period_cnt #(
    parameter int CW = tdc_pkg::CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wrap_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;

    // count ring periods, clear when idle, saturate at the top
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!start_i)
            cnt_q <= '0;
        else if (wrap_i && cnt_q != CMAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R2: the counter only steps by one, returns to zero, or holds
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

    // R2: the counter never goes down while start stays high
    p_cnt_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_i) && start_i) |-> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/tdc_phase_dec.sv
// Fine phase decoder for an odd inverting ring. It undoes the alternate
// inversion, counts the ones and the transitions, and derives a phase 0..2N-1.
// Bubbled patterns are resolved by the count of ones and flagged.
module tdc_phase_dec #(
    parameter int NSTG = tdc_pkg::NSTG,
    parameter int PW   = tdc_pkg::PW
) (
    input  logic [NSTG-1:0] tap_i,
    output logic [PW-1:0]   phase_o,
    output logic            bubble_o
);
    localparam int NPH = 2 * NSTG;

    logic [NSTG-1:0] norm;
    logic [NSTG-2:0] edge_w;

    // remove the inversion of every odd stage
    for (genvar k = 0; k < NSTG; k++) begin : g_norm
        assign norm[k] = tap_i[k] ^ ((k % 2) == 1);
    end

    // mark each neighbour pair that differs
    for (genvar k = 0; k < NSTG - 1; k++) begin : g_edge
        assign edge_w[k] = norm[k] ^ norm[k+1];
    end

    int ones;
    int trans;

    // count ones and transitions, then map to a phase
    always_comb begin
        ones  = 0;
        trans = 0;
        for (int k = 0; k < NSTG; k++)
            ones = ones + int'(norm[k]);
        for (int k = 0; k < NSTG - 1; k++)
            trans = trans + int'(edge_w[k]);
        if (norm[0])
            phase_o = PW'(ones);
        else if (ones == 0)
            phase_o = '0;
        else
            phase_o = PW'(NPH - ones);
        bubble_o = (trans > 1);
    end

    // R3: a decoded phase always lies inside one ring period
    always_comb begin
        p_phase_range_r3: assert (int'(phase_o) < NPH);
    end
endmodule

// File: rtl/tdc_code_merge.sv
// Merges the period count and the fine phase into a saturated output code.
module tdc_code_merge #(
    parameter int CW   = tdc_pkg::CW,
    parameter int PW   = tdc_pkg::PW,
    parameter int NPH  = tdc_pkg::NPH,
    parameter int OW   = tdc_pkg::OW
) (
    input  logic [CW-1:0] cnt_i,
    input  logic [PW-1:0] phase_i,
    output logic [OW-1:0] code_o
);
    localparam int CMAX = (1 << OW) - 1;
    localparam int SATC = CMAX / NPH + 1;

    int full;

    // weight the count by the period and clamp to the code range
    always_comb begin
        full = int'(cnt_i) * NPH + int'(phase_i);
        if (full > CMAX)
            code_o = OW'(CMAX);
        else
            code_o = OW'(full);
    end

    // R5: a count that alone passes the range forces the maximum code
    always_comb begin
        if (int'(cnt_i) >= SATC)
            p_sat_code_r5: assert (int'(code_o) == CMAX);
    end
endmodule

// File: rtl/tdc_ring_encoder.sv
// Two-step ring-oscillator time encoder, top level.
// Stage 1 captures the taps and the period count on the stop strobe.
// Stage 2 registers the merged code and raises valid for one cycle.
// Assumes the taps are stable in the cycle where stop_i is high.
module tdc_ring_encoder #(
    parameter int NSTG = tdc_pkg::NSTG,
    parameter int CW   = tdc_pkg::CW,
    parameter int OW   = tdc_pkg::OW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            wrap_i,
    input  logic            stop_i,
    input  logic [NSTG-1:0] tap_i,
    output logic [OW-1:0]   code_o,
    output logic            valid_o,
    output logic            bubble_o
);
    localparam int NPH = 2 * NSTG;
    localparam int PW  = $clog2(NPH);

    logic [CW-1:0]   cnt;
    logic [NSTG-1:0] s_tap;
    logic [CW-1:0]   s_cnt;
    logic            s_v;
    logic [PW-1:0]   phase;
    logic            bub;
    logic [OW-1:0]   code_c;

    tdc_period_cnt #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .wrap_i  (wrap_i),
        .cnt_o   (cnt)
    );

    // capture taps and period count at the stop strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_tap <= '0;
            s_cnt <= '0;
            s_v   <= 1'b0;
        end else begin
            s_v <= stop_i;
            if (stop_i) begin
                s_tap <= tap_i;
                s_cnt <= cnt;
            end
        end
    end

    tdc_phase_dec #(.NSTG(NSTG), .PW(PW)) u_dec (
        .tap_i    (s_tap),
        .phase_o  (phase),
        .bubble_o (bub)
    );

    tdc_code_merge #(.CW(CW), .PW(PW), .NPH(NPH), .OW(OW)) u_mrg (
        .cnt_i   (s_cnt),
        .phase_i (phase),
        .code_o  (code_c)
    );

    // register the result and pulse valid one clock after the capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o   <= '0;
            valid_o  <= 1'b0;
            bubble_o <= 1'b0;
        end else begin
            valid_o <= s_v;
            if (s_v) begin
                code_o   <= code_c;
                bubble_o <= bub;
            end
        end
    end

    // R6: every stop strobe yields a valid pulse two edges later
    p_valid_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> ##1 valid_o);

    // R6: valid appears only after a stop strobe
    p_valid_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(stop_i, 2));

    // R7: the bubble flag changes only together with a new valid result
    p_bubble_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(bubble_o));
endmodule

// File: tb/sim_tdc_ring_encoder.sv
`timescale 1ns/1ps
module sim_tdc_ring_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       wrap_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [8:0] tap_i = '0;
    logic [5:0] code_o;
    logic       valid_o;
    logic       bubble_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    string tag = "R4";

    always #2.5 clk = ~clk;

    tdc_ring_encoder u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wrap_i(wrap_i),
        .stop_i(stop_i), .tap_i(tap_i), .code_o(code_o),
        .valid_o(valid_o), .bubble_o(bubble_o)
    );

    // ring model: the tap levels for a given phase
    function automatic logic [8:0] ring_taps(int ph);
        logic [8:0] n;
        for (int k = 0; k < 9; k++)
            n[k] = (ph < 9) ? (k < ph) : (k >= ph - 9);
        return n ^ 9'b010101010;
    endfunction

    // expected phase and bubble flag taken from the requirement rules
    function automatic int exp_phase(logic [8:0] t, output bit bub);
        logic [8:0] n;
        int c;
        int tr;
        n = t ^ 9'b010101010;
        c = 0;
        tr = 0;
        for (int k = 0; k < 9; k++) c += int'(n[k]);
        for (int k = 0; k < 8; k++) tr += int'(n[k] != n[k+1]);
        bub = (tr > 1);
        if (n[0]) return c;
        if (c == 0) return 0;
        return 18 - c;
    endfunction

    // reference model state
    int    m_cnt = 0;
    bit    s_v = 0, e_v = 0;
    int    s_code = 0, e_code = 0;
    bit    s_bub = 0, e_bub = 0;
    string s_tag = "", e_tag = "";

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; s_v = 0; e_v = 0;
        end else begin
            e_v = s_v;
            if (s_v) begin e_code = s_code; e_bub = s_bub; e_tag = s_tag; end
            s_v = stop_i;
            if (stop_i) begin
                bit b;
                int full;
                full = m_cnt * 18 + exp_phase(tap_i, b);
                s_code = (full > 63) ? 63 : full;
                s_bub = b;
                s_tag = tag;
            end
            if (!start_i) m_cnt = 0;
            else if (wrap_i && m_cnt < 15) m_cnt = m_cnt + 1;
        end
    end

    // compare against the model on every falling edge once reset is over
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (valid_o !== e_v) begin
                n_bad++;
                $display("FAIL R6 valid_o=%0b expected=%0b", valid_o, e_v);
            end
            if (e_v) begin
                n_chk++;
                if (code_o !== 6'(e_code) || bubble_o !== e_bub) begin
                    n_bad++;
                    $display("FAIL %s code=%0d bubble=%0b expected code=%0d bubble=%0b",
                             e_tag, code_o, bubble_o, e_code, e_bub);
                end
            end
        end
    end

    task automatic measure(int periods, logic [8:0] taps, string t);
        tag = t;
        @(negedge clk) start_i = 1'b1;
        for (int i = 0; i < periods; i++) begin
            @(negedge clk) wrap_i = 1'b1;
            @(negedge clk) wrap_i = 1'b0;
        end
        @(negedge clk) begin stop_i = 1'b1; tap_i = taps; end
        @(negedge clk) begin stop_i = 1'b0; start_i = 1'b0; end
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (code_o !== 6'd0 || valid_o !== 1'b0 || bubble_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 code=%0d valid=%0b bubble=%0b expected 0 0 0",
                     code_o, valid_o, bubble_o);
        end
        @(negedge clk) rst_n = 1'b1;

        measure(0, ring_taps(0), "R4");
        // R3: every legal phase inside one period
        for (int p = 0; p < 18; p++) measure(1, ring_taps(p), "R3");
        measure(2, ring_taps(7), "R4");
        measure(3, ring_taps(9), "R5");
        measure(3, ring_taps(10), "R5");
        measure(5, ring_taps(3), "R5");
        measure(20, ring_taps(1), "R2");

        // R2: wraps while start is low are not counted
        tag = "R2";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) wrap_i = 1'b1;
            @(negedge clk) wrap_i = 1'b0;
        end
        @(negedge clk) begin stop_i = 1'b1; tap_i = ring_taps(4); end
        @(negedge clk) stop_i = 1'b0;
        repeat (3) @(negedge clk);

        // R4: a wrap at the stop edge is excluded
        tag = "R4";
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) wrap_i = 1'b1;
        @(negedge clk) begin stop_i = 1'b1; tap_i = ring_taps(2); end
        @(negedge clk) begin stop_i = 1'b0; wrap_i = 1'b0; start_i = 1'b0; end
        repeat (3) @(negedge clk);

        // R6: back-to-back stop strobes
        tag = "R6";
        @(negedge clk) begin start_i = 1'b1; stop_i = 1'b1; tap_i = ring_taps(5); end
        @(negedge clk) tap_i = ring_taps(12);
        @(negedge clk) begin stop_i = 1'b0; start_i = 1'b0; end
        repeat (3) @(negedge clk);

        // R7: bubbled patterns
        measure(0, 9'b000001101 ^ 9'b010101010, "R7");
        measure(1, 9'b110100000 ^ 9'b010101010, "R7");
        measure(2, 9'b101010101 ^ 9'b010101010, "R7");
        measure(0, ring_taps(6), "R7");

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) cycles++;
endmodule